// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block holds wall-clock time and calendar date as packed BCD bytes and advances them from a single-cycle tick enable that is nominally 64 Hz. A prescaler divides the tick by a parameterised count to produce one seconds increment. That increment ripples through minutes, a 24-hour hour field, the day of week, the date, the month and a two-digit year. The date field follows the length of each month. February gains a 29th day whenever the two-digit year is a multiple of four. A century bit flips each time the year wraps.

Software-side logic loads any field through a byte write port and reads any field back through a select-driven read port. A stop input freezes the chain and clears the prescaler. After stop is released, the first second is half a period long, so a known phase can be set before time is loaded. An oscillator-fail flag sits in the seconds byte. It comes up set from reset and can only be cleared by a write.

Field select codes on both ports: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 none.

Top module: `bcd_calendar_chain`

## Requirements
- R1: Seconds and minutes step through 00..59 in BCD. Stepping past 59 returns the field to 00 and advances the next field by one.
- R2: Hours step through 00..23 in BCD. Stepping past 23 returns hours to 00 and advances both the day of week and the date in the same cycle.
- R3: Day of week (select 3, bits 2:0) steps 0..6 and then returns to 0.
- R4: Date ends at 31 in months 01, 03, 05, 07, 08, 10 and 12, and at 30 in months 04, 06, 09 and 11. Stepping past the last date gives 01 and advances the month.
- R5: In month 02, date ends at 29 when the BCD year is divisible by four (00 included) and at 28 otherwise.
- R6: Month steps 01..12. Stepping past 12 gives 01 and advances the year. The year steps 00..99, and its wrap from 99 to 00 inverts the century bit (bit 7 of the month byte, select 5).
- R7: While stop is 1, the prescaler is held at zero and no field advances, even when ticks arrive.
- R8: After reset, or after stop returns to 0, the first seconds increment falls on the 32nd tick. Each later increment falls on every 64th tick.
- R9: The oscillator-fail flag is bit 7 of the seconds byte (select 0). It reads 1 after reset. A seconds write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged.
- R10: A write lands on the clock edge where it is presented and overrides any increment or carry into that same field on that edge. Carries into the other fields still proceed.
- R11: Unused bits read as 0 (seconds 6:0 plus flag, minutes 6:0, hours 5:0, day of week 2:0, date 5:0, month 4:0 plus century, year 7:0). Select 7 reads 0x00, and a write to select 7 changes nothing.
- R12: Reset gives 00:00:00, day of week 0, date 01, month 01, year 00, century 0 and the oscillator-fail flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle prescaler tick enable (nominally 64 Hz) |
| stop_i | input | 1 | Freeze counting and clear the prescaler |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Byte written into the selected field |
| rd_sel_i | input | 3 | Field select for readback |
| rd_data_o | output | 8 | Selected field, unused bits zero |

## Verification
The bench builds the block with the default divide of 64 and pulses the tick on every clock, so one second lasts 64 cycles. This makes the exact 32-tick first period and the 64-tick later periods countable edge by edge. Each calendar boundary is reached by writing the fields to one second before the boundary and then taking a single half-period step after a stop pulse. This covers every month-length class, the leap rule on BCD years such as 10 and 12, and the century flip within a few thousand cycles.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } field_e;

    typedef struct packed {
        logic       osf;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] date;
        logic       century;
        logic [4:0] month;
        logic [7:0] year;
    } clock_state_t;

    // BCD successor of a two-digit value (no wrap handling; callers wrap).
    function automatic logic [7:0] bcd_succ(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Two-digit BCD year divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4.
    function automatic logic bcd_leap(input logic [7:0] y);
        logic [1:0] r;
        r = y[1:0] + {y[4], 1'b0};
        return (r == 2'b00);
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic stop_i,
    output logic sec_pulse_o
);
    localparam int W    = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int HALF = TICKS / 2;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (stop_i)                        cnt_d = '0;
        else if (tick_i) begin
            if (cnt_q == W'(TICKS - 1))    cnt_d = '0;
            else                           cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Firing at the midpoint gives a half period from a cleared count.
    assign sec_pulse_o = tick_i && !stop_i && (cnt_q == W'(HALF - 1));

endmodule

// File: rtl/cal_month_limit.sv
module cal_month_limit (
    input  logic [4:0] month_i,
    input  logic       leap_i,
    output logic [5:0] last_o
);
    always_comb begin
        case (month_i)
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
            5'h02:                      last_o = leap_i ? 6'h29 : 6'h28;
            default:                    last_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/cal_readmux.sv
module cal_readmux
    import cal_pkg::*;
(
    input  clock_state_t st_i,
    input  logic [2:0]   sel_i,
    output logic [7:0]   data_o
);
    always_comb begin
        case (field_e'(sel_i))
            FLD_SEC:   data_o = {st_i.osf, st_i.sec};
            FLD_MIN:   data_o = {1'b0, st_i.min};
            FLD_HOUR:  data_o = {2'b00, st_i.hour};
            FLD_WDAY:  data_o = {5'b00000, st_i.wday};
            FLD_DATE:  data_o = {2'b00, st_i.date};
            FLD_MONTH: data_o = {st_i.century, 2'b00, st_i.month};
            FLD_YEAR:  data_o = st_i.year;
            default:   data_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       stop_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    input  logic [2:0] rd_sel_i,
    output logic [7:0] rd_data_o
);
    localparam clock_state_t RESET_STATE = '{
        osf: 1'b1, sec: 7'h00, min: 7'h00, hour: 6'h00, wday: 3'd0,
        date: 6'h01, century: 1'b0, month: 5'h01, year: 8'h00
    };

    clock_state_t st_d, st_q;
    logic         sec_pulse;
    logic [5:0]   last_date;
    logic         min_step, hour_step, day_step, mon_step, year_step;

    cal_prescaler #(.TICKS(TICKS_PER_SEC)) i_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .stop_i      (stop_i),
        .sec_pulse_o (sec_pulse)
    );

    cal_month_limit i_month_limit (
        .month_i (st_q.month),
        .leap_i  (bcd_leap(st_q.year)),
        .last_o  (last_date)
    );

    cal_readmux i_readmux (
        .st_i   (st_q),
        .sel_i  (rd_sel_i),
        .data_o (rd_data_o)
    );

    always_comb begin
        st_d      = st_q;
        min_step  = sec_pulse && (st_q.sec   == 7'h59);
        hour_step = min_step  && (st_q.min   == 7'h59);
        day_step  = hour_step && (st_q.hour  == 6'h23);
        mon_step  = day_step  && (st_q.date  == last_date);
        year_step = mon_step  && (st_q.month == 5'h12);

        if (sec_pulse)
            st_d.sec = min_step ? 7'h00 : 7'(bcd_succ({1'b0, st_q.sec}));
        if (min_step)
            st_d.min = hour_step ? 7'h00 : 7'(bcd_succ({1'b0, st_q.min}));
        if (hour_step)
            st_d.hour = day_step ? 6'h00 : 6'(bcd_succ({2'b00, st_q.hour}));
        if (day_step) begin
            st_d.wday = (st_q.wday == 3'd6) ? 3'd0 : st_q.wday + 3'd1;
            st_d.date = mon_step ? 6'h01 : 6'(bcd_succ({2'b00, st_q.date}));
        end
        if (mon_step)
            st_d.month = year_step ? 5'h01 : 5'(bcd_succ({3'b000, st_q.month}));
        if (year_step) begin
            if (st_q.year == 8'h99) begin
                st_d.year    = 8'h00;
                st_d.century = ~st_q.century;
            end else begin
                st_d.year = bcd_succ(st_q.year);
            end
        end

        if (wr_en_i) begin
            case (field_e'(wr_sel_i))
                FLD_SEC: begin
                    st_d.osf = st_q.osf & wr_data_i[7];
                    st_d.sec = wr_data_i[6:0];
                end
                FLD_MIN:   st_d.min  = wr_data_i[6:0];
                FLD_HOUR:  st_d.hour = wr_data_i[5:0];
                FLD_WDAY:  st_d.wday = wr_data_i[2:0];
                FLD_DATE:  st_d.date = wr_data_i[5:0];
                FLD_MONTH: begin
                    st_d.century = wr_data_i[7];
                    st_d.month   = wr_data_i[4:0];
                end
                FLD_YEAR:  st_d.year = wr_data_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cal_chain_checker.sv
module cal_chain_checker
    import cal_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         stop_i,
    input logic         wr_en_i,
    input logic [2:0]   wr_sel_i,
    input logic [7:0]   wr_data_i,
    input clock_state_t st_q
);
    assert_sec_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sec <= 7'h59 && !(wr_en_i && wr_sel_i == 3'd0)) |=> (st_q.sec <= 7'h59));

    assert_hour_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hour <= 6'h23 && !(wr_en_i && wr_sel_i == 3'd2)) |=> (st_q.hour <= 6'h23));

    assert_wday_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wday <= 3'd6 && !(wr_en_i && wr_sel_i == 3'd3)) |=> (st_q.wday <= 3'd6));

    assert_century_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en_i && wr_sel_i == 3'd5) && st_q.year != 8'h99) |=> $stable(st_q.century));

    assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !wr_en_i) |=> $stable(st_q));

    assert_osf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.osf |=> !st_q.osf);

    assert_min_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd1) |=> (st_q.min == $past(wr_data_i[6:0])));

    assert_month_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd5) |=> (st_q.century == $past(wr_data_i[7])));
endmodule

bind bcd_calendar_chain cal_chain_checker i_cal_chain_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .st_q      (st_q)
);

// File: tb/test_bcd_calendar_chain.sv
`timescale 1ns/1ps
module test_bcd_calendar_chain;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = 3'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic [2:0] rd_sel_i = 3'd0;
    logic [7:0] rd_data_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [2:0] sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    bcd_calendar_chain #(.TICKS_PER_SEC(64)) i_bcd_calendar_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .stop_i    (stop_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o)
    );

    // Monitor: compares the readback against the queued expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (rd_data_o !== it.exp) begin
                n_fails++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, rd_data_o, it.exp);
            end
        end
    end

    task automatic check(input logic [2:0] sel, input logic [7:0] exp, input string tag);
        item_t it;
        rd_sel_i = sel;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(posedge clk); #1;
        end
        tick_i = 1'b0;
    endtask

    // Clear the prescaler, then take one half-period second.
    task automatic bump();
        stop_i = 1'b1;
        @(posedge clk); #1;
        stop_i = 1'b0;
        ticks(32);
    endtask

    task automatic set_eod(input logic [7:0] wd, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23);
        wr(3'd3, wd); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state, R9 flag set, R11 select 7 reads zero
        check(3'd0, 8'h80, "R12 sec+flag");
        check(3'd1, 8'h00, "R12 min");
        check(3'd2, 8'h00, "R12 hour");
        check(3'd3, 8'h00, "R12 wday");
        check(3'd4, 8'h01, "R12 date");
        check(3'd5, 8'h01, "R12 month");
        check(3'd6, 8'h00, "R12 year");
        check(3'd7, 8'h00, "R11 none");

        // R8 first increment on the 32nd tick, then every 64th
        ticks(31); check(3'd0, 8'h80, "R8 before 32");
        ticks(1);  check(3'd0, 8'h81, "R8 at 32");
        ticks(63); check(3'd0, 8'h81, "R8 before 64");
        ticks(1);  check(3'd0, 8'h82, "R8 at 64");

        // R9 flag clear and no re-set
        wr(3'd0, 8'h00); check(3'd0, 8'h00, "R9 cleared");
        wr(3'd0, 8'h85); check(3'd0, 8'h05, "R9 write one ignored");

        // R7 stop freezes
        stop_i = 1'b1; ticks(100); stop_i = 1'b0;
        check(3'd0, 8'h05, "R7 frozen");
        // R8 after stop release: 32 ticks
        ticks(31); check(3'd0, 8'h05, "R8 post-stop before 32");
        ticks(1);  check(3'd0, 8'h06, "R8 post-stop at 32");

        // R1 second and minute carries
        wr(3'd0, 8'h59); wr(3'd1, 8'h12); wr(3'd2, 8'h05); bump();
        check(3'd0, 8'h00, "R1 sec wrap");
        check(3'd1, 8'h13, "R1 min carry");
        wr(3'd0, 8'h59); wr(3'd1, 8'h59); bump();
        check(3'd1, 8'h00, "R1 min wrap");
        check(3'd2, 8'h06, "R1 hour carry");

        // R2/R3 day rollover
        set_eod(8'h06, 8'h15, 8'h03, 8'h21); bump();
        check(3'd2, 8'h00, "R2 hour wrap");
        check(3'd3, 8'h00, "R3 wday wrap");
        check(3'd4, 8'h16, "R2 date step");
        check(3'd5, 8'h03, "R2 month kept");

        // R4 month lengths
        set_eod(8'h02, 8'h30, 8'h04, 8'h21); bump();
        check(3'd4, 8'h01, "R4 apr30 date"); check(3'd5, 8'h05, "R4 apr30 month");
        check(3'd3, 8'h03, "R3 wday step");
        set_eod(8'h00, 8'h29, 8'h04, 8'h21); bump();
        check(3'd4, 8'h30, "R4 apr29");
        set_eod(8'h00, 8'h31, 8'h01, 8'h21); bump();
        check(3'd4, 8'h01, "R4 jan31 date"); check(3'd5, 8'h02, "R4 jan31 month");
        set_eod(8'h00, 8'h30, 8'h06, 8'h21); bump();
        check(3'd5, 8'h07, "R4 jun30 month");
        set_eod(8'h00, 8'h30, 8'h08, 8'h21); bump();
        check(3'd4, 8'h31, "R4 aug30");

        // R5 leap rule
        set_eod(8'h00, 8'h28, 8'h02, 8'h24); bump();
        check(3'd4, 8'h29, "R5 24 leap");
        set_eod(8'h00, 8'h29, 8'h02, 8'h24); bump();
        check(3'd5, 8'h03, "R5 24 end");
        set_eod(8'h00, 8'h28, 8'h02, 8'h23); bump();
        check(3'd4, 8'h01, "R5 23 date"); check(3'd5, 8'h03, "R5 23 month");
        set_eod(8'h00, 8'h28, 8'h02, 8'h00); bump();
        check(3'd4, 8'h29, "R5 00 leap");
        set_eod(8'h00, 8'h28, 8'h02, 8'h10); bump();
        check(3'd4, 8'h01, "R5 10 common");
        set_eod(8'h00, 8'h28, 8'h02, 8'h12); bump();
        check(3'd4, 8'h29, "R5 12 leap");

        // R6 year and century
        set_eod(8'h00, 8'h31, 8'h12, 8'h24); bump();
        check(3'd5, 8'h01, "R6 month wrap"); check(3'd6, 8'h25, "R6 year step");
        set_eod(8'h00, 8'h31, 8'h12, 8'h99); bump();
        check(3'd6, 8'h00, "R6 year wrap"); check(3'd5, 8'h81, "R6 century set");
        set_eod(8'h00, 8'h31, 8'h92, 8'h99); bump();
        check(3'd5, 8'h01, "R6 century clear");

        // R10 write wins on the increment edge
        stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        wr(3'd0, 8'h20);
        ticks(31);
        tick_i = 1'b1; wr(3'd0, 8'h40); tick_i = 1'b0;
        check(3'd0, 8'h40, "R10 sec write vs step");
        wr(3'd0, 8'h59); wr(3'd1, 8'h10);
        stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        ticks(31);
        tick_i = 1'b1; wr(3'd1, 8'h30); tick_i = 1'b0;
        check(3'd0, 8'h00, "R10 sec still wraps");
        check(3'd1, 8'h30, "R10 min write vs carry");

        // R11 masking and ignored select
        wr(3'd3, 8'hF5); check(3'd3, 8'h05, "R11 wday mask");
        wr(3'd7, 8'hFF);
        check(3'd1, 8'h30, "R11 sel7 min");
        check(3'd3, 8'h05, "R11 sel7 wday");
        check(3'd7, 8'h00, "R11 sel7 read");

        @(posedge clk); #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule